// File: doc/BRIEF.md
# Session Seed Entropy Mixer

The block builds a one-time session seed. Several free-running toggle sources with no timing relation to the system clock are each brought into the clock domain through a two-flop synchronizer. The synchronized bits are XOR-folded into one entropy bit per cycle. That bit is injected into the feedback of a 64-bit LFSR accumulator. The accumulator runs for a fixed number of system-clock cycles that begins at reset release.

An external seed, taken from off-chip non-volatile storage, is accepted once over a valid/ready handshake. When the window has closed and the external seed is held, the block XORs the two values and presents the result with a single-cycle strobe. The result then stays frozen until the next reset. A replayed external seed still gives a different session seed unless the on-chip entropy also repeats. Harvesting runs once per reset, right after start-up, before the sources can settle into lock with the system clock.

Top module: `session_seed_mixer`

## Requirements
- R1: Each bit of `ent_i` passes through two flip-flops clocked by `clk_i` before any combining logic. An input level present at edge j reaches the combiner at edge j+2. The synchronizer flops reset to 0.
- R2: The synchronized inputs are reduced by XOR to one entropy bit per clock cycle.
- R3: The accumulator is 64 bits wide and resets to zero. On each harvest cycle it shifts toward the MSB. The new bit 0 is `acc[63]^acc[62]^acc[60]^acc[59]^entropy_bit`.
- R4: The harvest window covers exactly `WIN_CYC` clock edges, counted from the first edge after `rst_ni` rises. After the window the accumulator is frozen, so later entropy activity does not affect the seed.
- R5: `ext_ready_o` is 1 from reset until the first edge at which `ext_valid_i` is 1. It then stays 0 until reset. Any later `ext_valid_i` pulse, including one carrying different data, has no effect on `seed_o`.
- R6: `seed_valid_o` pulses for exactly one cycle. The pulse comes one cycle after the later of two events: the window closing, or the external seed being captured. It occurs only once per reset.
- R7: `seed_o` is `ext_seed XOR acc`. If the accumulator is zero at the end of the window, the constant 64'h9E3779B97F4A7C15 is used in place of `acc`.
- R8: From the pulse on, `seed_o` holds its value and `done_o` stays 1 until reset.
- R9: During reset, `seed_o` is 0, `seed_valid_o` is 0, `done_o` is 0 and `ext_ready_o` is 1.
- R10: Two sessions with the same external seed but different entropy activity produce different `seed_o` values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (crystal-derived reference) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ent_i | input | N_SRC | Asynchronous entropy toggle sources |
| ext_seed_i | input | 64 | External seed value |
| ext_valid_i | input | 1 | External seed valid |
| ext_ready_o | output | 1 | Block can accept the external seed |
| seed_o | output | 64 | Mixed session seed |
| seed_valid_o | output | 1 | One-cycle strobe when `seed_o` is first valid |
| done_o | output | 1 | Harvest finished, seed final |

## Verification
A wrong synchronizer depth or tap position leaves the pulse timing correct but changes the accumulated word. Such a fault therefore shows only in the value of `seed_o` at the strobe, about `WIN_CYC` cycles after reset. A window counter that is off by one gives the same symptom, and it also shifts the strobe by one edge when the external seed arrives early. Handshake faults appear within one cycle as a wrong `ext_ready_o` level, or later as a strobe in the wrong cycle or a seed built from the second, ignored transfer.

// File: rtl/seed_mix_pkg.sv
`timescale 1ns/1ps
package seed_mix_pkg;
  localparam int unsigned SEED_W = 64;
  typedef logic [SEED_W-1:0] seed_t;

  // substitute for an all-zero accumulator
  localparam seed_t LOCKUP_FILL = 64'h9E37_79B9_7F4A_7C15;

  function automatic logic acc_feedback(seed_t s);
    return s[63] ^ s[62] ^ s[60] ^ s[59];
  endfunction
endpackage

// File: rtl/entropy_sync.sv
`timescale 1ns/1ps
module entropy_sync #(
  parameter int unsigned N_SRC = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] async_i,
  output logic             bit_o
);
  logic [N_SRC-1:0] meta_q;
  logic [N_SRC-1:0] safe_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[g] <= 1'b0;
        safe_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= async_i[g];
        safe_q[g] <= meta_q[g];
      end
    end
  end

  assign bit_o = ^safe_q;
endmodule

// File: rtl/entropy_acc.sv
`timescale 1ns/1ps
module entropy_acc
  import seed_mix_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  shift_en_i,
  input  logic  bit_i,
  output seed_t state_o
);
  seed_t state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         state_q <= '0;
    else if (shift_en_i) state_q <= {state_q[SEED_W-2:0], acc_feedback(state_q) ^ bit_i};
  end

  assign state_o = state_q;
endmodule

// File: rtl/harvest_ctrl.sv
`timescale 1ns/1ps
module harvest_ctrl
  import seed_mix_pkg::*;
#(
  parameter int unsigned WIN_CYC = 4096
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  seed_t acc_i,
  input  seed_t ext_seed_i,
  input  logic  ext_valid_i,
  output logic  ext_ready_o,
  output logic  shift_en_o,
  output seed_t seed_o,
  output logic  seed_valid_o,
  output logic  done_o
);
  localparam int unsigned CNT_W = $clog2(WIN_CYC + 1);
  localparam logic [CNT_W-1:0] WIN_END = CNT_W'(WIN_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic             have_q;
  seed_t            ext_q;
  seed_t            seed_q;
  logic             valid_q;
  logic             done_q;
  logic             win_closed;
  logic             fire;
  seed_t            acc_safe;

  assign win_closed  = (cnt_q == WIN_END);
  assign shift_en_o  = !win_closed;
  assign ext_ready_o = !have_q;
  assign fire        = win_closed && have_q && !done_q;
  assign acc_safe    = (acc_i == '0) ? LOCKUP_FILL : acc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!win_closed) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      ext_q  <= '0;
    end else if (ext_valid_i && !have_q) begin
      have_q <= 1'b1;
      ext_q  <= ext_seed_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seed_q  <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= fire;
      if (fire) begin
        seed_q <= ext_q ^ acc_safe;
        done_q <= 1'b1;
      end
    end
  end

  assign seed_o       = seed_q;
  assign seed_valid_o = valid_q;
  assign done_o       = done_q;

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_valid_o |=> !seed_valid_o);                                  // R6
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);                                               // R8
  AST_SEED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> $stable(seed_o));                                      // R8
  AST_READY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_valid_i && ext_ready_o) |=> !ext_ready_o);                   // R5
  AST_NO_EARLY_SEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_valid_o |-> !shift_en_o);                                    // R6
endmodule

// File: rtl/session_seed_mixer.sv
`timescale 1ns/1ps
module session_seed_mixer
  import seed_mix_pkg::*;
#(
  parameter int unsigned N_SRC   = 3,
  parameter int unsigned WIN_CYC = 4096
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] ent_i,
  input  logic [63:0]      ext_seed_i,
  input  logic             ext_valid_i,
  output logic             ext_ready_o,
  output logic [63:0]      seed_o,
  output logic             seed_valid_o,
  output logic             done_o
);
  logic  ent_bit;
  logic  shift_en;
  seed_t acc;

  entropy_sync #(.N_SRC(N_SRC)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ent_i),
    .bit_o   (ent_bit)
  );

  entropy_acc u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (shift_en),
    .bit_i      (ent_bit),
    .state_o    (acc)
  );

  harvest_ctrl #(.WIN_CYC(WIN_CYC)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .acc_i        (acc),
    .ext_seed_i   (ext_seed_i),
    .ext_valid_i  (ext_valid_i),
    .ext_ready_o  (ext_ready_o),
    .shift_en_o   (shift_en),
    .seed_o       (seed_o),
    .seed_valid_o (seed_valid_o),
    .done_o       (done_o)
  );

  AST_ACC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en |=> $stable(acc));                                      // R4
endmodule

// File: tb/session_seed_mixer_bench.sv
`timescale 1ns/1ps
module session_seed_mixer_bench;
  localparam int unsigned N_SRC   = 3;
  localparam int unsigned WIN_CYC = 4096;
  localparam logic [63:0] FILL    = 64'h9E3779B97F4A7C15;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [N_SRC-1:0] ent_i = '0;
  logic [63:0]      ext_seed_i = '0;
  logic             ext_valid_i = 1'b0;
  logic             ext_ready_o;
  logic [63:0]      seed_o;
  logic             seed_valid_o;
  logic             done_o;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  session_seed_mixer #(.N_SRC(N_SRC), .WIN_CYC(WIN_CYC)) u_session_seed_mixer (
    .clk_i, .rst_ni, .ent_i, .ext_seed_i, .ext_valid_i,
    .ext_ready_o, .seed_o, .seed_valid_o, .done_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic run_session(input logic [63:0] ext, input int arrive,
                             input bit zero_ent, output logic [63:0] got);
    logic [63:0] m;
    logic        h1, h2, fb, mready;
    int          cap, fire_edge, seen, dbl, rdy_err, last;
    logic [63:0] expv;
    rst_ni = 1'b0; ent_i = '0; ext_valid_i = 1'b0; ext_seed_i = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R9 reset state
    chk(seed_o == '0 && !seed_valid_o && !done_o && ext_ready_o, "R9", "reset state",
        {seed_o[60:0], seed_valid_o, done_o, ext_ready_o}, 64'h1);
    rst_ni = 1'b1;
    m = '0; h1 = 1'b0; h2 = 1'b0; mready = 1'b1;
    cap = -1; seen = -1; dbl = 0; rdy_err = 0; got = '0;
    fire_edge = ((arrive > int'(WIN_CYC)) ? arrive : int'(WIN_CYC)) + 1;
    last = fire_edge + 30;
    for (int j = 1; j <= last; j++) begin
      if (!zero_ent)
        for (int s = 0; s < N_SRC; s++)
          if ($urandom % 3 == 0) ent_i[s] = ~ent_i[s];
      ext_valid_i = 1'b0;
      if (j >= arrive && mready) begin
        ext_valid_i = 1'b1; ext_seed_i = ext;
      end else if (cap > 0 && j >= cap + 3 && j < cap + 8) begin
        ext_valid_i = 1'b1; ext_seed_i = ~ext;  // must be ignored (R5)
      end
      if (ext_ready_o !== mready) rdy_err++;
      if (ext_valid_i && mready) begin mready = 1'b0; cap = j; end
      if (j <= int'(WIN_CYC)) begin
        fb = m[63] ^ m[62] ^ m[60] ^ m[59];
        m  = {m[62:0], fb ^ h2};
      end
      h2 = h1;
      h1 = ^ent_i;
      @(posedge clk_i);
      @(negedge clk_i);
      if (seed_valid_o) begin
        if (seen < 0) begin seen = j; got = seed_o; end
        else dbl++;
      end
    end
    expv = ext ^ ((m == '0) ? FILL : m);
    chk(rdy_err == 0, "R5", "ready level mismatches", 64'(rdy_err), 64'd0);
    chk(seen == fire_edge, "R6", "strobe edge", 64'(seen), 64'(fire_edge));
    chk(got == expv, "R3", "mixed seed value (R1 R2 R4 R7)", got, expv);
    chk(dbl == 0, "R6", "extra strobes", 64'(dbl), 64'd0);
    chk(seed_o == got, "R8", "seed held after strobe", seed_o, got);
    chk(done_o == 1'b1, "R8", "done sticky", 64'(done_o), 64'd1);
    chk(ext_ready_o == 1'b0, "R5", "ready stays low", 64'(ext_ready_o), 64'd0);
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk_i);
        if (!finished) begin
          total++; bad++;
          $display("FAIL watchdog act=timeout exp=finish");
          $display("test done: total=%0d bad=%0d", total, bad);
          $finish;
        end
      end
    join_none
  end

  initial begin
    logic [63:0] s1, s2, s3;
    logic [63:0] ext_a;
    void'($urandom(32'h5EED_1234));
    ext_a = {$urandom, $urandom};
    // R10: replay of the same external seed with fresh entropy
    run_session(ext_a, 10, 1'b0, s1);
    run_session(ext_a, 10, 1'b0, s2);
    chk(s1 != s2, "R10", "replayed seed differs", s2, ~s1);
    // R6: external seed arrives after the window
    run_session({$urandom, $urandom}, WIN_CYC + 20, 1'b0, s3);
    // R7: no entropy activity, all-zero accumulator
    run_session(64'h0123_4567_89AB_CDEF, 5, 1'b1, s3);
    chk(s3 == (64'h0123_4567_89AB_CDEF ^ FILL), "R7", "lock-up substitute",
        s3, 64'h0123_4567_89AB_CDEF ^ FILL);
    // R4 R6: arrival on the last window edge
    run_session({$urandom, $urandom}, WIN_CYC, 1'b0, s3);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule